// File: doc/BRIEF.md
# Next-PC Selection Unit

This unit holds the program counter of a 32-bit RISC core and works out, each cycle, which address to fetch next. The instruction at the current PC arrives on `instr_i`, together with a flag that reports whether the instruction's two register operands are equal. The unit decodes the major opcode in bits 31:26. It then picks the sequential address, a PC-relative branch target or a region-relative jump target, and loads that choice into the PC on the next clock edge. There are no delay slots, so a taken transfer redirects the very next fetch.

Branch offsets in bits 15:0 count instructions. They are sign-extended, scaled by four and added to the incremented PC, so negative values reach earlier code such as loop back-edges. A jump keeps the top four bits of the incremented PC and places the 26-bit index from bits 25:0 below them, with two zero bits at the bottom. An optional port lets the surrounding core force an externally computed target, for example a register-indirect jump resolved elsewhere. It is built in when `HAS_IND` is 1.

Top module: `npc_unit`

## Requirements
- R1: While `rst_ni` is low the PC equals `RESET_VEC` (default 0x00400000).
- R2: For an opcode (bits 31:26) other than 0x02, 0x04 or 0x05, with no forced target, `next_pc_o` is `pc_o + 4` and `redirect_o` is low.
- R3: Opcode 0x04 (branch if equal) with `cmp_eq_i` high gives `next_pc_o = pc_o + 4 + (sign_extend(instr_i[15:0]) << 2)` and raises `redirect_o`.
- R4: Opcode 0x04 with `cmp_eq_i` low gives `pc_o + 4` with `redirect_o` low.
- R5: Opcode 0x05 (branch if not equal) is taken exactly when `cmp_eq_i` is low, with the same target rule as R3; otherwise `pc_o + 4`.
- R6: Offsets with bit 15 set move the PC backwards, with 32-bit wrap-around, down to the most negative offset 0x8000.
- R7: Opcode 0x02 (jump) gives `{pc4[31:28], instr_i[25:0], 2'b00}`, where `pc4 = pc_o + 4`, whatever `cmp_eq_i` is, and raises `redirect_o`.
- R8: With `HAS_IND = 1`, `ind_jump_i` high makes `next_pc_o` equal `ind_target_i` with `redirect_o` high, overriding any decoded instruction.
- R9: `redirect_o` is high exactly when `next_pc_o` comes from a branch, jump or forced target, not from the sequential path.
- R10: After reset is released, every rising clock edge loads `pc_o` with the `next_pc_o` value present before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction fetched at `pc_o` |
| cmp_eq_i | input | 1 | High when the two register operands are equal |
| ind_jump_i | input | 1 | Force `ind_target_i` as the next PC |
| ind_target_i | input | 32 | Externally resolved target |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Address to be loaded on the next edge |
| redirect_o | output | 1 | Next PC is non-sequential |

## Verification
The bench builds the unit with `HAS_IND = 1` and the default reset vector. The forced-target path is what makes the awkward spots reachable. It can place the PC at 0x0FFFFFFC, so a following jump shows that the top four bits come from the incremented PC (0x1) and not from the current PC (0x0). It can also place the PC low in the address space, so a most-negative branch offset wraps through zero. Random opcodes mixed with equal and unequal comparison flags cover both outcomes of both branch kinds over many PC values.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned OFF_W  = 16;
  localparam int unsigned JIDX_W = 26;
  localparam int unsigned ILEN_B = 4;
  localparam int unsigned ALIGN_W = $clog2(ILEN_B);
  localparam int unsigned REGION_W = XLEN - JIDX_W - ALIGN_W;

  localparam logic [OPC_W-1:0] OPC_JMP = 6'h02;
  localparam logic [OPC_W-1:0] OPC_BEQ = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNE = 6'h05;

  typedef enum logic [1:0] {
    SEL_SEQ = 2'd0,
    SEL_BR  = 2'd1,
    SEL_JMP = 2'd2,
    SEL_IND = 2'd3
  } npc_sel_e;

  typedef struct packed {
    logic              is_beq;
    logic              is_bne;
    logic              is_jmp;
    logic [OFF_W-1:0]  off;
    logic [JIDX_W-1:0] jidx;
  } npc_dec_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output npc_dec_t        dec_o
);
  logic [OPC_W-1:0] opc;
  assign opc = instr_i[XLEN-1 -: OPC_W];

  always_comb begin
    dec_o        = '0;
    dec_o.is_beq = (opc == OPC_BEQ);
    dec_o.is_bne = (opc == OPC_BNE);
    dec_o.is_jmp = (opc == OPC_JMP);
    dec_o.off    = instr_i[OFF_W-1:0];
    dec_o.jidx   = instr_i[JIDX_W-1:0];
  end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]   pc_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [JIDX_W-1:0] jidx_i,
  output logic [XLEN-1:0]   pc4_o,
  output logic [XLEN-1:0]   br_tgt_o,
  output logic [XLEN-1:0]   jmp_tgt_o
);
  logic [XLEN-1:0] off_ext;

  assign pc4_o   = pc_i + XLEN'(ILEN_B);
  // offset counts instructions: sign-extend, then scale
  assign off_ext = {{(XLEN-OFF_W-ALIGN_W){off_i[OFF_W-1]}}, off_i, {ALIGN_W{1'b0}}};
  assign br_tgt_o = pc4_o + off_ext;
  // region bits come from the incremented PC
  assign jmp_tgt_o = {pc4_o[XLEN-1 -: REGION_W], jidx_i, {ALIGN_W{1'b0}}};
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter bit HAS_IND = 1'b1
) (
  input  npc_dec_t        dec_i,
  input  logic            cmp_eq_i,
  input  logic            ind_jump_i,
  input  logic [XLEN-1:0] ind_target_i,
  input  logic [XLEN-1:0] pc4_i,
  input  logic [XLEN-1:0] br_tgt_i,
  input  logic [XLEN-1:0] jmp_tgt_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            redirect_o
);
  npc_sel_e sel;
  logic     br_taken;
  logic     ind_req;

  assign br_taken = (dec_i.is_beq & cmp_eq_i) | (dec_i.is_bne & ~cmp_eq_i);

  generate
    if (HAS_IND) begin : g_ind
      assign ind_req = ind_jump_i;
    end else begin : g_no_ind
      logic unused_ind;
      assign unused_ind = ind_jump_i ^ (^ind_target_i);
      assign ind_req    = 1'b0;
    end
  endgenerate

  always_comb begin
    if (ind_req)           sel = SEL_IND;
    else if (dec_i.is_jmp) sel = SEL_JMP;
    else if (br_taken)     sel = SEL_BR;
    else                   sel = SEL_SEQ;
  end

  always_comb begin
    unique case (sel)
      SEL_IND: next_pc_o = ind_target_i;
      SEL_JMP: next_pc_o = jmp_tgt_i;
      SEL_BR:  next_pc_o = br_tgt_i;
      default: next_pc_o = pc4_i;
    endcase
  end

  assign redirect_o = (sel != SEL_SEQ);
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg
  import npc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] d_i,
  output logic [XLEN-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RESET_VEC;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000,
  parameter bit          HAS_IND   = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] instr_i,
  input  logic        cmp_eq_i,
  input  logic        ind_jump_i,
  input  logic [31:0] ind_target_i,
  output logic [31:0] pc_o,
  output logic [31:0] next_pc_o,
  output logic        redirect_o
);
  npc_dec_t        dec;
  logic [XLEN-1:0] pc4, br_tgt, jmp_tgt;

  npc_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  npc_targets u_tgt (
    .pc_i      (pc_o),
    .off_i     (dec.off),
    .jidx_i    (dec.jidx),
    .pc4_o     (pc4),
    .br_tgt_o  (br_tgt),
    .jmp_tgt_o (jmp_tgt)
  );

  npc_select #(.HAS_IND(HAS_IND)) u_sel (
    .dec_i        (dec),
    .cmp_eq_i     (cmp_eq_i),
    .ind_jump_i   (ind_jump_i),
    .ind_target_i (ind_target_i),
    .pc4_i        (pc4),
    .br_tgt_i     (br_tgt),
    .jmp_tgt_i    (jmp_tgt),
    .next_pc_o    (next_pc_o),
    .redirect_o   (redirect_o)
  );

  npc_pc_reg #(.RESET_VEC(RESET_VEC)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (next_pc_o),
    .q_o    (pc_o)
  );
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000,
  parameter bit          HAS_IND   = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] instr_i,
  input logic        cmp_eq_i,
  input logic        ind_jump_i,
  input logic [31:0] ind_target_i,
  input logic [31:0] pc_o,
  input logic [31:0] next_pc_o,
  input logic        redirect_o
);
  logic [5:0]  opc;
  logic [31:0] pc4;
  logic        ind_act;
  assign opc     = instr_i[31:26];
  assign pc4     = pc_o + 32'd4;
  assign ind_act = HAS_IND && ind_jump_i;

  // R1
  a_r1_reset_vec: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> pc_o == RESET_VEC);

  // R2, R9
  a_r2_sequential: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ind_act && opc != 6'h02 && opc != 6'h04 && opc != 6'h05)
      |-> (next_pc_o == pc4 && !redirect_o));

  // R4
  a_r4_beq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ind_act && opc == 6'h04 && !cmp_eq_i) |-> (next_pc_o == pc4 && !redirect_o));

  // R5
  a_r5_bne_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ind_act && opc == 6'h05 && cmp_eq_i) |-> (next_pc_o == pc4 && !redirect_o));

  // R7
  a_r7_jump_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ind_act && opc == 6'h02)
      |-> (next_pc_o[31:28] == pc4[31:28] && next_pc_o[1:0] == 2'b00 && redirect_o));

  // R8
  a_r8_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ind_act |-> (next_pc_o == ind_target_i && redirect_o));

  // R10
  a_r10_pc_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> pc_o == $past(next_pc_o));
endmodule

bind npc_unit npc_unit_chk #(.RESET_VEC(RESET_VEC), .HAS_IND(HAS_IND)) u_npc_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .instr_i      (instr_i),
  .cmp_eq_i     (cmp_eq_i),
  .ind_jump_i   (ind_jump_i),
  .ind_target_i (ind_target_i),
  .pc_o         (pc_o),
  .next_pc_o    (next_pc_o),
  .redirect_o   (redirect_o)
);

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;
  localparam logic [31:0] RST_VEC = 32'h0040_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i = '0;
  logic        cmp_eq_i = 1'b0;
  logic        ind_jump_i = 1'b0;
  logic [31:0] ind_target_i = '0;
  logic [31:0] pc_o, next_pc_o;
  logic        redirect_o;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_pc;

  always #4 clk_i = ~clk_i;

  npc_unit #(.RESET_VEC(RST_VEC), .HAS_IND(1'b1)) u_npc_unit (
    .clk_i, .rst_ni, .instr_i, .cmp_eq_i, .ind_jump_i, .ind_target_i,
    .pc_o, .next_pc_o, .redirect_o
  );

  function automatic logic [31:0] model_next(logic [31:0] pc, logic [31:0] ins,
                                              logic eq, logic ind, logic [31:0] tgt);
    logic [31:0] p4;
    p4 = pc + 32'd4;
    if (ind) return tgt;
    case (ins[31:26])
      6'h02: return {p4[31:28], ins[25:0], 2'b00};
      6'h04: return eq  ? p4 + ({{16{ins[15]}}, ins[15:0]} << 2) : p4;
      6'h05: return !eq ? p4 + ({{16{ins[15]}}, ins[15:0]} << 2) : p4;
      default: return p4;
    endcase
  endfunction

  function automatic logic model_redir(logic [31:0] ins, logic eq, logic ind);
    if (ind) return 1'b1;
    case (ins[31:26])
      6'h02: return 1'b1;
      6'h04: return eq;
      6'h05: return !eq;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // one cycle: called at negedge; checks PC, drives, checks comb outputs
  task automatic step(string req, logic [31:0] ins, logic eq, logic ind, logic [31:0] tgt);
    logic [31:0] en;
    check32({req, " R10 pc"}, pc_o, exp_pc);
    instr_i = ins; cmp_eq_i = eq; ind_jump_i = ind; ind_target_i = tgt;
    #1;
    en = model_next(exp_pc, ins, eq, ind, tgt);
    check32({req, " next"}, next_pc_o, en);
    check32({req, " R9 redirect"}, {31'd0, redirect_o}, {31'd0, model_redir(ins, eq, ind)});
    exp_pc = en;
    @(negedge clk_i);
  endtask

  function automatic logic [31:0] rand_instr();
    logic [31:0] r;
    int k;
    r = $urandom;
    k = $urandom_range(0, 3);
    case (k)
      0: r[31:26] = 6'h02;
      1: r[31:26] = 6'h04;
      2: r[31:26] = 6'h05;
      default: if (r[31:26] inside {6'h02, 6'h04, 6'h05}) r[31:26] = 6'h08;
    endcase
    return r;
  endfunction

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    exp_pc = RST_VEC;
    repeat (3) @(negedge clk_i);
    check32("R1 reset", pc_o, RST_VEC);
    rst_ni = 1'b1;

    // R2 sequential, R4/R5 not taken
    step("R2", 32'h2008_0001, 1'b1, 1'b0, '0);
    step("R4", {6'h04, 10'd0, 16'h0010}, 1'b0, 1'b0, '0);
    step("R5", {6'h05, 10'd0, 16'h0010}, 1'b1, 1'b0, '0);
    // R3 forward taken
    step("R3", {6'h04, 10'd0, 16'h0010}, 1'b1, 1'b0, '0);
    step("R5 taken", {6'h05, 10'd0, 16'h0003}, 1'b0, 1'b0, '0);
    // R6 backward: -1 lands on itself, loop back-edge -4
    step("R6 self", {6'h04, 10'd0, 16'hFFFF}, 1'b1, 1'b0, '0);
    step("R6 loop", {6'h05, 10'd0, 16'hFFFC}, 1'b0, 1'b0, '0);
    // R6 most negative offset wrapping through zero
    step("R8", 32'h0, 1'b0, 1'b1, 32'h0000_0100);
    step("R6 min", {6'h04, 10'd0, 16'h8000}, 1'b1, 1'b0, '0);
    check32("R6 wrap", exp_pc, 32'h0000_0104 - 32'h0002_0000);
    // R7 region from incremented PC
    step("R8", 32'h0, 1'b0, 1'b1, 32'h0FFF_FFFC);
    step("R7 region", {6'h02, 26'h000_0010}, 1'b0, 1'b0, '0);
    check32("R7 region", exp_pc, 32'h1000_0040);
    step("R7 eq", {6'h02, 26'h3FF_FFFF}, 1'b1, 1'b0, '0);
    // R8 override of a jump
    step("R8 over", {6'h02, 26'h0}, 1'b1, 1'b1, 32'h0040_0200);

    for (int i = 0; i < 3000; i++) begin
      logic ind;
      ind = ($urandom_range(0, 15) == 0);
      step("rand R3 R5 R7", rand_instr(), 1'(($urandom) & 1), ind, {$urandom, 2'b00} >> 2 << 2);
    end

    // R1 again: async reset mid-run
    rst_ni = 1'b0;
    #1;
    check32("R1 reassert", pc_o, RST_VEC);
    @(negedge clk_i);
    rst_ni = 1'b1;
    exp_pc = RST_VEC;
    step("R2 after reset", 32'h0000_0020, 1'b0, 1'b0, '0);
    check32("R10 final", pc_o, exp_pc);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule